// File: doc/BRIEF.md
# Shadowed Timekeeper Register Interface

This block holds a 64-byte register map for a battery-backed timekeeper. A host reaches it over an asynchronous-SRAM style bus with active-low chip select, output enable and write enable, and a 6-bit address. Every bus pin is sampled on a system clock. The low fourteen locations hold user-visible copies of the time, date, alarm and watchdog counters. Location 0x0B is a host-only command byte, and 0x0E through 0x3F are plain user RAM.

The counters are outside this block. They present a parallel snapshot, one byte per low location, with a valid pulse. The block copies all of these bytes into the map in a single clock edge. It waits for a quiet bus before doing so, so a host never sees a half-updated time. When the host writes a counter location, the block updates the visible copy and also sends a load strobe to the counter logic with the location index and the byte.

A power-fail input blocks host access. A write cycle that sees power-fail is discarded, and reads produce no output while it is high.

Top module: `tk_regfile`

## Requirements
- R1: All 64 locations (address 0x00 to 0x3F) store a byte written by the host and return it on a later read; locations 0x0E to 0x3F are touched only by the host.
- R2: A read cycle is any cycle with cs_n=0, oe_n=0 and we_n=1. In the next cycle rdata_oe=1 and rdata holds the addressed byte; in all other cases rdata_oe=0.
- R3: A write cycle is any run of cycles with cs_n=0 and we_n=0. It ends in the first cycle where either signal is high. The address and data from the last active cycle are stored on the clock edge that ends that first inactive cycle.
- R4: If we_n goes low while a read cycle is in progress, rdata_oe is 0 from the next cycle on.
- R5: A stored write to a counter location produces ld_stb=1 for exactly one cycle, with ld_idx equal to the address and ld_data equal to the byte. Counter locations are addresses 0x00 to 0x0D except 0x0B. Writes to 0x0B or to any address of 0x0E or above produce no strobe.
- R6: A host write to a counter location also updates the visible copy, and a later read returns the written byte.
- R7: A snapshot is taken on a cycle with snap_valid=1. Byte i of snap_data (bits 8i+7:8i, i = 0 to 13) replaces location i, and all bytes are replaced on the same clock edge.
- R8: A snapshot is not applied while the bus is busy. Busy means a read cycle, a write cycle, or the storing cycle that follows a write. The snapshot is applied at the first non-busy edge. If a newer snapshot arrives while one is pending, the newer one replaces it.
- R9: A write cycle during which pwr_fail is 1 in any cycle, including the ending cycle, changes no location and produces no load strobe. While pwr_fail=1, rdata_oe stays 0.
- R10: The command location 0x0B is written only by the host; snapshots leave it unchanged.
- R11: After reset every location reads 0x00, and rdata_oe and ld_stb are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data |
| pwr_fail | input | 1 | Supply out of tolerance; blocks host access |
| snap_valid | input | 1 | Snapshot present on snap_data |
| snap_data | input | 112 | Counter bytes; byte i goes to location i |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | Read data driven |
| ld_stb | output | 1 | Counter load strobe |
| ld_idx | output | 4 | Counter location being loaded |
| ld_data | output | 8 | Byte to load into the counter |

## Verification
The bench holds a read open across two back-to-back snapshots. It checks that the visible byte stays old for the whole read and that only the second snapshot lands afterwards. A design that updates mid-access, or keeps the first snapshot, fails this check.

A multi-cycle write with changing data checks that the final byte is stored; a design that latches on the leading edge would store the first byte. A read turned into a write checks that the output driver drops.

Power-fail is raised in the active cycle of one write and only in the ending cycle of another. A design that checks only one of these cycles corrupts a location or sends a load strobe. Snapshots are also checked to leave the command byte alone.

// File: rtl/tk_regfile.sv
module tk_regfile #(
  parameter int AW       = 6,
  parameter int DW       = 8,
  parameter int NSHD     = 14,
  parameter int CMD_ADDR = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 oe_n,
  input  logic                 we_n,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic                 pwr_fail,
  input  logic                 snap_valid,
  input  logic [NSHD*DW-1:0]   snap_data,
  output logic [DW-1:0]        rdata,
  output logic                 rdata_oe,
  output logic                 ld_stb,
  output logic [$clog2(NSHD)-1:0] ld_idx,
  output logic [DW-1:0]        ld_data
);
  localparam int DEPTH = 1 << AW;
  localparam int IW    = $clog2(NSHD);

  logic [DW-1:0] mem [DEPTH];

  logic              wr_q, wr_bad, pend;
  logic [AW-1:0]     wa_q;
  logic [DW-1:0]     wd_q;
  logic [NSHD*DW-1:0] pend_data;

  wire rd_act     = ~cs_n & ~oe_n & we_n;
  wire wr_act     = ~cs_n & ~we_n;
  wire commit     = wr_q & ~wr_act;
  wire commit_ok  = commit & ~wr_bad & ~pwr_fail;
  wire busy       = rd_act | wr_act | wr_q;
  wire snap_apply = pend & ~busy;
  wire wa_shd     = (wa_q < AW'(NSHD)) && (wa_q != AW'(CMD_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      wr_bad <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      wr_q <= wr_act;
      if (wr_act) begin
        wa_q <= addr;
        wd_q <= wdata;
      end
      wr_bad <= commit ? 1'b0 : (wr_bad | (wr_act & pwr_fail));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_data <= '0;
    end else if (snap_valid) begin
      pend      <= 1'b1;
      pend_data <= snap_data;
    end else if (snap_apply) begin
      pend <= 1'b0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    wire hit = commit_ok && (wa_q == AW'(g));
    if (g < NSHD && g != CMD_ADDR) begin : g_shd
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          mem[g] <= '0;
        else if (hit)        mem[g] <= wd_q;
        else if (snap_apply) mem[g] <= pend_data[g*DW +: DW];
      end
    end else begin : g_usr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mem[g] <= '0;
        else if (hit) mem[g] <= wd_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
      ld_stb   <= 1'b0;
      ld_idx   <= '0;
      ld_data  <= '0;
    end else begin
      rdata_oe <= rd_act & ~pwr_fail;
      rdata    <= rd_act ? mem[addr] : '0;
      ld_stb   <= commit_ok & wa_shd;
      ld_idx   <= wa_q[IW-1:0];
      ld_data  <= wd_q;
    end
  end

  // R4
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> !rdata_oe);
  // R9
  pf_noload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !ld_stb);
  // R9
  pf_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !rdata_oe);
  // R5
  ld_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |-> (ld_idx != IW'(CMD_ADDR)) && (ld_idx < IW'(NSHD)));
  // R3
  ld_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |-> $past(cs_n || we_n) && $past(!cs_n && !we_n, 2));
  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=> $stable(mem[0]));
endmodule

// File: tb/tk_regfile_tb.sv
module tk_regfile_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic pwr_fail = 1'b0, snap_valid = 1'b0;
  logic [111:0] snap_data = '0;
  logic [7:0] rdata, ld_data;
  logic rdata_oe, ld_stb;
  logic [3:0] ld_idx;

  int total = 0, bad = 0;
  logic [7:0]  rd_q[$];
  string       rd_t[$];
  logic [11:0] ld_q[$];
  string       ld_t[$];

  always #5 clk = ~clk;

  tk_regfile dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .pwr_fail(pwr_fail), .snap_valid(snap_valid),
    .snap_data(snap_data), .rdata(rdata), .rdata_oe(rdata_oe), .ld_stb(ld_stb),
    .ld_idx(ld_idx), .ld_data(ld_data));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rdata_oe) begin
      if (rd_q.size() == 0) chk("R2 unexpected read", {24'd0, rdata}, 32'hFFFF_FFFF);
      else chk(rd_t.pop_front(), {24'd0, rdata}, {24'd0, rd_q.pop_front()});
    end
    if (ld_stb) begin
      if (ld_q.size() == 0) chk("R5 unexpected load", {20'd0, ld_idx, ld_data}, 32'hFFFF_FFFF);
      else chk(ld_t.pop_front(), {20'd0, ld_idx, ld_data}, {20'd0, ld_q.pop_front()});
    end
  end

  task automatic bus_write(input logic [5:0] a, input logic [7:0] d, input int n = 1);
    if (a < 6'd14 && a != 6'd11) begin ld_q.push_back({a[3:0], d}); ld_t.push_back("R5 load strobe"); end
    @(negedge clk);
    cs_n = 0; we_n = 0; addr = a; wdata = ~d;
    for (int k = 1; k < n; k++) @(negedge clk);
    wdata = d;
    @(negedge clk);
    cs_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [5:0] a, input logic [7:0] e, input string tag);
    rd_q.push_back(e); rd_t.push_back(tag);
    @(negedge clk);
    cs_n = 0; oe_n = 0; addr = a;
    @(negedge clk);
    cs_n = 1; oe_n = 1;
  endtask

  function automatic logic [111:0] mk_snap(input logic [7:0] base, input logic [7:0] step);
    logic [111:0] v;
    for (int i = 0; i < 14; i++) v[i*8 +: 8] = base + 8'(i) * step;
    return v;
  endfunction

  task automatic snap(input logic [111:0] v);
    @(negedge clk);
    snap_valid = 1; snap_data = v;
    @(negedge clk);
    snap_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 rdata_oe", {31'd0, rdata_oe}, 0);
    chk("R11 ld_stb", {31'd0, ld_stb}, 0);
    bus_read(6'h00, 8'h00, "R11 loc 0");
    bus_read(6'h20, 8'h00, "R11 loc 20");
    // R1 user RAM
    bus_write(6'h0E, 8'h3C);
    bus_write(6'h3F, 8'h5A);
    bus_write(6'h20, 8'h33);
    bus_read(6'h0E, 8'h3C, "R1 loc 0E");
    bus_read(6'h3F, 8'h5A, "R1 loc 3F");
    bus_read(6'h20, 8'h33, "R1 loc 20");
    // R3 last active byte wins
    bus_write(6'h10, 8'h77, 4);
    bus_read(6'h10, 8'h77, "R3 long write");
    // R5 R6 counter writes, R10 command
    bus_write(6'h02, 8'h45);
    bus_write(6'h0C, 8'h12);
    bus_write(6'h0B, 8'h81);
    bus_read(6'h02, 8'h45, "R6 loc 02");
    bus_read(6'h0C, 8'h12, "R6 loc 0C");
    bus_read(6'h0B, 8'h81, "R10 cmd write");
    // R4 read turned into write
    rd_q.push_back(8'h3C); rd_t.push_back("R4 pre read");
    @(negedge clk);
    cs_n = 0; oe_n = 0; addr = 6'h0E; wdata = 8'hA5;
    @(negedge clk);
    we_n = 0;
    @(negedge clk);
    chk("R4 rdata_oe off", {31'd0, rdata_oe}, 0);
    cs_n = 1; oe_n = 1; we_n = 1;
    @(negedge clk);
    bus_read(6'h0E, 8'hA5, "R3 write after read");
    // R7 idle snapshot
    snap(mk_snap(8'h11, 8'h11));
    bus_read(6'h00, 8'h11, "R7 loc 0");
    bus_read(6'h02, 8'h33, "R7 loc 2");
    bus_read(6'h05, 8'h66, "R7 loc 5");
    bus_read(6'h0D, 8'hEE, "R7 loc D");
    bus_read(6'h0B, 8'h81, "R10 cmd kept");
    bus_read(6'h3F, 8'h5A, "R1 ram kept");
    // R8 snapshots during a held read
    for (int k = 0; k < 6; k++) begin rd_q.push_back(8'h66); rd_t.push_back("R8 held read"); end
    @(negedge clk);
    cs_n = 0; oe_n = 0; addr = 6'h05;
    @(negedge clk); snap_valid = 1; snap_data = mk_snap(8'h10, 8'h01);
    @(negedge clk); snap_data = mk_snap(8'h50, 8'h01);
    @(negedge clk); snap_valid = 0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); cs_n = 1; oe_n = 1;
    repeat (2) @(negedge clk);
    bus_read(6'h05, 8'h55, "R8 newest applied");
    bus_read(6'h00, 8'h50, "R8 loc 0");
    bus_read(6'h0D, 8'h5D, "R8 loc D");
    bus_read(6'h0B, 8'h81, "R10 cmd kept 2");
    // R9 power fail
    @(negedge clk);
    pwr_fail = 1; cs_n = 0; oe_n = 0; addr = 6'h0E;
    @(negedge clk);
    chk("R9 no read output", {31'd0, rdata_oe}, 0);
    cs_n = 1; oe_n = 1; pwr_fail = 0;
    @(negedge clk);
    @(negedge clk);
    cs_n = 0; we_n = 0; addr = 6'h20; wdata = 8'hEE; pwr_fail = 1;
    @(negedge clk);
    cs_n = 1; we_n = 1; pwr_fail = 0;
    repeat (2) @(negedge clk);
    bus_read(6'h20, 8'h33, "R9 active-cycle fail");
    @(negedge clk);
    cs_n = 0; we_n = 0; addr = 6'h01; wdata = 8'h99;
    @(negedge clk);
    cs_n = 1; we_n = 1; pwr_fail = 1;
    @(negedge clk);
    pwr_fail = 0;
    chk("R9 no load strobe", {31'd0, ld_stb}, 0);
    @(negedge clk);
    bus_read(6'h01, 8'h51, "R9 end-cycle fail");
    repeat (3) @(negedge clk);
    chk("R2 reads all seen", rd_q.size(), 0);
    chk("R5 loads all seen", ld_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule